// File: doc/BRIEF.md
# Port I/O Configuration-Space Redirector

This block decodes port-I/O accesses. Each access carries a port number, an access size in bytes and a read/write direction, plus write data. The block decides where the access lands and reports the physical target, a flag for the internal register, and whether the target exists. It is a purely decoding stage. Bus transactions and device responses belong to the logic around it.

The block implements the legacy two-register configuration mechanism. A 32-bit write to port 0xCF8 loads an internal configuration-address register. Accesses to ports 0xCFC to 0xCFF are then sent into a configuration-space physical region. Their target address is built from the stored register and the low two port bits. Bit 31 of the register enables that redirection. Every other port, including a narrow access to 0xCF8, maps flatly into an I/O physical region.

The decode is combinational and settles in the cycle the request is presented. Only the configuration-address register holds state.

Top module: `pio_cfg_redirect`

## Requirements
- R1: After reset the configuration-address register holds zero. A 4-byte read of port 0xCF8 returns 0, and a data-window access is unmapped.
- R2: A request whose port has any bit above bit 15 set raises `port_err`. It has `map_valid`, `reg_access` and `unmapped` low and `phys_addr` zero.
- R3: A request of exactly 4 bytes to port 0xCF8 raises `reg_access` and `map_valid` and drives `phys_addr` to zero. A read also returns the stored register value on `rdata`.
- R4: A 4-byte write to port 0xCF8 stores `req_wdata` at the next rising clock edge. Later reads of the register return the stored value.
- R5: An access to port 0xCF8 of any size other than 4 is an ordinary I/O access. It leaves the configuration-address register unchanged.
- R6: When register bit 31 is set, an access to ports 0xCFC–0xCFF maps to the configuration prefix (0xC000_0000_0000). The prefix is OR-ed with register bits 30:2, placed at address bits 30:2, and with port bits 1:0 at address bits 1:0. `map_valid` is high.
- R7: When register bit 31 is clear, a data-window access has `unmapped` high, `map_valid` low and `phys_addr` zero. A read of it returns all ones on `rdata`.
- R8: Any other valid 16-bit port maps to the I/O prefix (0x8000_0000_0000) OR-ed with the port number, with `map_valid` high.
- R9: Writes to the data window do not change the configuration-address register.
- R10: With `req_valid` low, all flags are low, and `phys_addr` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 32 | Port number; only bits 15:0 may be non-zero |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| phys_addr | output | 48 | Physical target address |
| reg_access | output | 1 | Access hits the configuration-address register |
| map_valid | output | 1 | A target exists and `phys_addr` is meaningful |
| unmapped | output | 1 | Data-window access while redirection is disabled |
| port_err | output | 1 | Port number wider than 16 bits |
| rdata | output | 32 | Read data for the register and for the disabled window |

## Verification
All decode outputs are combinational, so they are due in the same cycle the request is driven. The bench drives each request just after a falling edge and samples one nanosecond later, before the next rising edge. A register write takes effect at the following rising edge. The bench's model of the register therefore changes only after that edge, so a write followed by a window access or a read-back exercises the one-cycle update path exactly.

// File: rtl/pio_cfg_pkg.sv
package pio_cfg_pkg;

    localparam int PORT_IN_W = 32;
    localparam int PORT_W    = 16;
    localparam int PA_W      = 48;
    localparam int CFG_W     = 32;
    localparam int SIZE_W    = 4;

    localparam logic [PORT_W-1:0] ADDR_PORT   = 16'hCF8;
    localparam logic [PORT_W-1:0] WINDOW_PORT = 16'hCFC;
    localparam logic [SIZE_W-1:0] CFG_SIZE    = 4'd4;
    localparam int                EN_BIT      = CFG_W - 1;

    localparam logic [PA_W-1:0] IO_BASE  = 48'h8000_0000_0000;
    localparam logic [PA_W-1:0] CFG_BASE = 48'hC000_0000_0000;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_BADPORT,
        CLS_ADDRREG,
        CLS_WIN_ON,
        CLS_WIN_OFF,
        CLS_FLAT_IO
    } pio_class_e;

    typedef struct packed {
        logic [PA_W-1:0]  addr;
        logic             reg_hit;
        logic             valid;
        logic             unmapped;
        logic             bad_port;
        logic [CFG_W-1:0] rdata;
    } pio_result_t;

    function automatic logic in_window(input logic [PORT_W-1:0] p);
        return (p & ~16'h0003) == WINDOW_PORT;
    endfunction

    function automatic logic [PA_W-1:0] window_addr(
        input logic [CFG_W-1:0]  cfg,
        input logic [PORT_W-1:0] p
    );
        logic [PA_W-1:0] off;
        off = '0;
        off[EN_BIT-1:2] = cfg[EN_BIT-1:2];
        off[1:0]        = p[1:0];
        return CFG_BASE | off;
    endfunction

endpackage

// File: rtl/pio_port_classify.sv
module pio_port_classify
    import pio_cfg_pkg::*;
#(
    parameter int IN_W = PORT_IN_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IN_W-1:0]     req_port,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic                cfg_enable,
    output pio_class_e          cls
);
    logic upper_set;
    logic [PORT_W-1:0] p;

    assign p = req_port[PORT_W-1:0];

    generate
        if (IN_W > PORT_W) begin : g_upper
            assign upper_set = |req_port[IN_W-1:PORT_W];
        end else begin : g_noupper
            assign upper_set = 1'b0;
        end
    endgenerate

    always_comb begin
        if (!req_valid)
            cls = CLS_NONE;
        else if (upper_set)
            cls = CLS_BADPORT;
        else if (p == ADDR_PORT && req_size == CFG_SIZE)
            cls = CLS_ADDRREG;
        else if (in_window(p))
            cls = cfg_enable ? CLS_WIN_ON : CLS_WIN_OFF;
        else
            cls = CLS_FLAT_IO;
    end

    // R2: a wide port number never reaches a mapped class
    p_wide_port_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && upper_set) |-> (cls == CLS_BADPORT));

    // R5: a narrow access to the address port is flat I/O
    p_narrow_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !upper_set && p == ADDR_PORT && req_size != CFG_SIZE)
            |-> (cls == CLS_FLAT_IO));
endmodule

// File: rtl/pio_addr_reg.sv
module pio_addr_reg
    import pio_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_data;
    end

    // R4: a write is visible on the next cycle
    p_store_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wr_data)));

    // R9: without a write the register holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/pio_target_build.sv
module pio_target_build
    import pio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pio_class_e        cls,
    input  logic [PORT_W-1:0] port,
    input  logic              is_write,
    input  logic [CFG_W-1:0]  cfg_q,
    output pio_result_t       res
);
    always_comb begin
        res = '0;
        unique case (cls)
            CLS_BADPORT: res.bad_port = 1'b1;
            CLS_ADDRREG: begin
                res.reg_hit = 1'b1;
                res.valid   = 1'b1;
                if (!is_write)
                    res.rdata = cfg_q;
            end
            CLS_WIN_ON: begin
                res.valid = 1'b1;
                res.addr  = window_addr(cfg_q, port);
            end
            CLS_WIN_OFF: begin
                res.unmapped = 1'b1;
                if (!is_write)
                    res.rdata = '1;
            end
            CLS_FLAT_IO: begin
                res.valid = 1'b1;
                res.addr  = IO_BASE | {{(PA_W-PORT_W){1'b0}}, port};
            end
            default: res = '0;
        endcase
    end

    // R6: the low port bits survive into the window target
    p_window_low_r6: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_WIN_ON) |-> (res.addr[1:0] == port[1:0] && res.valid));

    // R7: a disabled window is never valid
    p_off_unmapped_r7: assert property (@(posedge clk) disable iff (rst)
        res.unmapped |-> (!res.valid && res.addr == '0));

    // R8: flat I/O targets keep the port in the low bits
    p_flat_io_r8: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_FLAT_IO) |-> (res.addr[PORT_W-1:0] == port));
endmodule

// File: rtl/pio_cfg_redirect.sv
module pio_cfg_redirect
    import pio_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PORT_IN_W-1:0] req_port,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic [CFG_W-1:0]     req_wdata,
    output logic [PA_W-1:0]      phys_addr,
    output logic                 reg_access,
    output logic                 map_valid,
    output logic                 unmapped,
    output logic                 port_err,
    output logic [CFG_W-1:0]     rdata
);
    pio_class_e  cls;
    pio_result_t res;
    logic [CFG_W-1:0] cfg_q;
    logic cfg_wr;

    pio_port_classify #(.IN_W(PORT_IN_W)) u_classify (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_port   (req_port),
        .req_size   (req_size),
        .cfg_enable (cfg_q[EN_BIT]),
        .cls        (cls)
    );

    assign cfg_wr = (cls == CLS_ADDRREG) && req_write;

    pio_addr_reg u_addr_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (req_wdata),
        .q       (cfg_q)
    );

    pio_target_build u_build (
        .clk      (clk),
        .rst      (rst),
        .cls      (cls),
        .port     (req_port[PORT_W-1:0]),
        .is_write (req_write),
        .cfg_q    (cfg_q),
        .res      (res)
    );

    assign phys_addr  = res.addr;
    assign reg_access = res.reg_hit;
    assign map_valid  = res.valid;
    assign unmapped   = res.unmapped;
    assign port_err   = res.bad_port;
    assign rdata      = res.rdata;

    // R2: an error excludes every other outcome
    p_err_excl_r2: assert property (@(posedge clk) disable iff (rst)
        port_err |-> (!map_valid && !reg_access && !unmapped));

    // R10: no request, no activity
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!map_valid && !reg_access && !unmapped && !port_err));

    // R3: a register hit reports a valid zero target
    p_reg_hit_r3: assert property (@(posedge clk) disable iff (rst)
        reg_access |-> (map_valid && phys_addr == '0));

    // R4: a write to the address register is seen on the next read
    p_readback_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && reg_access && req_write) |=>
            (cfg_q == $past(req_wdata)));
endmodule

// File: tb/test_pio_cfg_redirect.sv
module test_pio_cfg_redirect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_port = '0;
    logic [3:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [47:0] phys_addr;
    logic        reg_access, map_valid, unmapped, port_err;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_reg = '0;
    bit done = 0;

    always #2 clk = ~clk;

    pio_cfg_redirect i_pio_cfg_redirect (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .phys_addr(phys_addr), .reg_access(reg_access), .map_valid(map_valid),
        .unmapped(unmapped), .port_err(port_err), .rdata(rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected outputs from the requirements
    task automatic expect_of(input logic v, input logic [31:0] p,
                             input logic [3:0] s, input logic w,
                             output string tag, output logic [47:0] ea,
                             output logic er, output logic ev,
                             output logic eu, output logic ee,
                             output logic [31:0] ed);
        ea = '0; er = 0; ev = 0; eu = 0; ee = 0; ed = '0;
        if (!v) tag = "R10";
        else if (p[31:16] != 0) begin tag = "R2"; ee = 1; end
        else if (p[15:0] == 16'hCF8 && s == 4'd4) begin
            tag = "R3"; er = 1; ev = 1;
            if (!w) ed = model_reg;
        end else if (p[15:2] == 14'h33F) begin
            if (model_reg[31]) begin
                tag = "R6"; ev = 1;
                ea = 48'hC000_0000_0000 | {17'd0, model_reg[30:2], p[1:0]};
            end else begin
                tag = "R7"; eu = 1;
                if (!w) ed = '1;
            end
        end else begin
            tag = (p[15:0] == 16'hCF8) ? "R5" : "R8";
            ev = 1;
            ea = 48'h8000_0000_0000 | {32'd0, p[15:0]};
        end
    endtask

    task automatic do_req(input logic v, input logic [31:0] p,
                          input logic [3:0] s, input logic w,
                          input logic [31:0] d);
        string tag;
        logic [47:0] ea;
        logic er, ev, eu, ee;
        logic [31:0] ed;
        @(negedge clk);
        req_valid = v; req_port = p; req_size = s;
        req_write = w; req_wdata = d;
        #1;
        expect_of(v, p, s, w, tag, ea, er, ev, eu, ee, ed);
        chk(tag, "phys_addr", {16'd0, phys_addr}, {16'd0, ea});
        chk(tag, "reg_access", {63'd0, reg_access}, {63'd0, er});
        chk(tag, "map_valid", {63'd0, map_valid}, {63'd0, ev});
        chk(tag, "unmapped", {63'd0, unmapped}, {63'd0, eu});
        chk(tag, "port_err", {63'd0, port_err}, {63'd0, ee});
        chk(tag, "rdata", {32'd0, rdata}, {32'd0, ed});
        @(posedge clk);
        // R4: the register takes the write at this edge; R9 window writes do not
        if (v && p[31:16] == 0 && p[15:0] == 16'hCF8 && s == 4'd4 && w)
            model_reg = d;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rp;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: register zero after reset, window unmapped
        do_req(1, 32'hCF8, 4, 0, 0);
        do_req(1, 32'hCFD, 1, 0, 0);
        // R10 idle
        do_req(0, 32'hCF8, 4, 1, 32'hFFFF_FFFF);
        do_req(1, 32'hCF8, 4, 0, 0);
        // R2 wide port
        do_req(1, 32'h0001_0CF8, 4, 1, 32'h8000_0000);
        do_req(1, 32'h8000_0080, 1, 0, 0);
        // R4 write then read back, R6 window enabled
        do_req(1, 32'hCF8, 4, 1, 32'h8012_3456);
        do_req(1, 32'hCF8, 4, 0, 0);
        for (int i = 0; i < 4; i++) do_req(1, 32'hCFC + i, 1, 0, 0);
        // R5 narrow access at address port leaves register alone
        do_req(1, 32'hCF8, 2, 1, 32'h0000_0000);
        do_req(1, 32'hCF8, 1, 1, 32'h0000_0000);
        do_req(1, 32'hCF8, 4, 0, 0);
        // R9 window write does not change the register
        do_req(1, 32'hCFE, 4, 1, 32'h0);
        do_req(1, 32'hCF8, 4, 0, 0);
        // R8 neighbour ports and extremes
        do_req(1, 32'hCF7, 1, 0, 0);
        do_req(1, 32'hCF9, 4, 0, 0);
        do_req(1, 32'hD00, 4, 0, 0);
        do_req(1, 32'hFFFF, 1, 0, 0);
        do_req(1, 32'h0, 2, 0, 0);
        // R7 disable and read window
        do_req(1, 32'hCF8, 4, 1, 32'h7FFF_FFFF);
        do_req(1, 32'hCFF, 4, 0, 0);
        do_req(1, 32'hCFC, 4, 1, 32'h1);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 6)
                0: rp = 32'hCF8;
                1, 2: rp = 32'hCFC + ($urandom % 4);
                3: rp = $urandom % 32'h1_0000;
                4: rp = 32'hCF4 + ($urandom % 16);
                default: rp = $urandom;
            endcase
            do_req(($urandom % 8) != 0, rp,
                   (($urandom % 2) != 0) ? 4'd4 : 4'($urandom % 9),
                   ($urandom % 2) != 0, $urandom);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule